// File: doc/BRIEF.md
# External Interrupt Sense Unit

This block turns a set of external interrupt pins into per-pin interrupt requests. Every pin has its own two-bit sense selector, so it can raise a request on a low level, on a falling edge or on a rising edge. It also has its own enable bit and its own vector-acknowledge strobe. The pin level first passes through a reset-initialised synchronizer chain. Edges are then found by comparing the newest synchronized sample with the one taken a cycle earlier.

An edge-mode event is held in a per-pin flag until the CPU acknowledges the vector. A low-level request holds no state: it tracks the synchronized pin for as long as the pin stays low. The unit reads the pad level whatever drives it. Software can therefore raise an interrupt by driving its own pin as an output. In a typical build one dedicated pin and a group of four further pins share one instance, and their sense fields come from separate control registers outside the block.

Top module: `eis_top`

## Requirements
- R1: After reset `intReq` is all zero, all edge flags are clear, and the synchronizer holds the idle-high level.
- R2: In sense mode 2'b00 (low level, field bits [2i+1:2i] of `senseMode` for pin i), `intReq[i]` equals `intEnable[i]` AND NOT the synchronized pin. It rises two clocks after the pin goes low, stays high while the pin is low, and drops two clocks after the pin returns high.
- R3: In mode 2'b10 (falling edge), a high-to-low pin transition sets the pin's flag three clocks after the pin changes. The flag then holds until acknowledged.
- R4: In mode 2'b11 (rising edge), a low-to-high transition sets the flag in the same way. A falling transition has no effect in this mode.
- R5: Mode 2'b01 is reserved: the pin never raises a request and never sets its flag.
- R6: A high `vecAck[i]` clears flag i at the next clock. If a new edge sets the flag in that same clock, the set wins.
- R7: With `intEnable[i]` low, `intReq[i]` is low. An edge still sets the flag, and the request appears in the same cycle that the enable is raised.
- R8: Pins are independent: an acknowledge or an event on one pin leaves the other pins' flags and requests untouched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pinRaw | input | NUM_PINS | Pad levels, asynchronous |
| senseMode | input | 2*NUM_PINS | Per-pin sense selector, pin i in bits [2i+1:2i] |
| intEnable | input | NUM_PINS | Per-pin request enable |
| vecAck | input | NUM_PINS | Per-pin vector acknowledge strobe |
| intReq | output | NUM_PINS | Per-pin interrupt request |

## Verification
The bench builds the unit with NUM_PINS = 5 and SYNC_STAGES = 2, the shape of one dedicated pin plus a group of four. This lets the bench clear one pin while its neighbours keep pending flags, and run different sense modes side by side. Because the synchronizer depth is two, the two-clock level latency and the three-clock edge latency can be checked at exact cycles. A same-cycle collision of acknowledge and a new edge can also be set up by hand. Random pin toggles, acknowledges, enable flips and mode changes are then compared each cycle against a cycle model kept in the bench.

// File: rtl/eis_pkg.sv
package eis_pkg;

  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_RSVD = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_RISE = 2'b11
  } senseMode_e;

  // control -> datapath strobes for one pin
  typedef struct packed {
    logic setFlag;
    logic clrFlag;
  } flagStrobe_t;

endpackage

// File: rtl/eis_datapath.sv
module eis_datapath
  import eis_pkg::*;
#(
  parameter int NUM_PINS    = 5,
  parameter int SYNC_STAGES = 2,
  parameter bit IDLE_LEVEL  = 1'b1
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic        [NUM_PINS-1:0]   pinRaw,
  input  flagStrobe_t [NUM_PINS-1:0]   strobe,
  output logic        [NUM_PINS-1:0]   pinLvl,
  output logic        [NUM_PINS-1:0]   pinPrev,
  output logic        [NUM_PINS-1:0]   flag
);

  localparam int LAST = SYNC_STAGES - 1;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic [SYNC_STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        chain      <= {SYNC_STAGES{IDLE_LEVEL}};
        pinPrev[i] <= IDLE_LEVEL;
        flag[i]    <= 1'b0;
      end else begin
        chain      <= {chain[LAST-1:0], pinRaw[i]};
        pinPrev[i] <= chain[LAST];
        if (strobe[i].setFlag)      flag[i] <= 1'b1;
        else if (strobe[i].clrFlag) flag[i] <= 1'b0;
      end
    end

    assign pinLvl[i] = chain[LAST];

    // R3
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      (flag[i] && !strobe[i].clrFlag) |=> flag[i]);

    // R6
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
      (strobe[i].clrFlag && !strobe[i].setFlag) |=> !flag[i]);

    // R6
    set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
      strobe[i].setFlag |=> flag[i]);
  end

endmodule

// File: rtl/eis_control.sv
module eis_control
  import eis_pkg::*;
#(
  parameter int NUM_PINS = 5
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic        [NUM_PINS-1:0]   pinLvl,
  input  logic        [NUM_PINS-1:0]   pinPrev,
  input  logic        [NUM_PINS-1:0]   flag,
  input  logic        [2*NUM_PINS-1:0] senseMode,
  input  logic        [NUM_PINS-1:0]   intEnable,
  input  logic        [NUM_PINS-1:0]   vecAck,
  output flagStrobe_t [NUM_PINS-1:0]   strobe,
  output logic        [NUM_PINS-1:0]   intReq
);

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    senseMode_e mode;
    logic       fell;
    logic       rose;

    assign mode = senseMode_e'(senseMode[2*i +: 2]);
    assign fell = pinPrev[i] & ~pinLvl[i];
    assign rose = ~pinPrev[i] & pinLvl[i];

    always_comb begin
      strobe[i].setFlag = ((mode == SENSE_FALL) && fell) ||
                          ((mode == SENSE_RISE) && rose);
      strobe[i].clrFlag = vecAck[i];
      unique case (mode)
        SENSE_LOW:              intReq[i] = intEnable[i] & ~pinLvl[i];
        SENSE_FALL, SENSE_RISE: intReq[i] = intEnable[i] & flag[i];
        default:                intReq[i] = 1'b0;
      endcase
    end

    // R5
    rsvd_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
      (mode == SENSE_RSVD) |-> !intReq[i]);

    // R7
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
      !intEnable[i] |-> !intReq[i]);

    // R2
    level_high_chk: assert property (@(posedge clk) disable iff (!rstN)
      ((mode == SENSE_LOW) && pinLvl[i]) |-> !intReq[i]);
  end

endmodule

// File: rtl/eis_top.sv
module eis_top
  import eis_pkg::*;
#(
  parameter int NUM_PINS    = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [NUM_PINS-1:0]     pinRaw,
  input  logic [2*NUM_PINS-1:0]   senseMode,
  input  logic [NUM_PINS-1:0]     intEnable,
  input  logic [NUM_PINS-1:0]     vecAck,
  output logic [NUM_PINS-1:0]     intReq
);

  logic        [NUM_PINS-1:0] pinLvl;
  logic        [NUM_PINS-1:0] pinPrev;
  logic        [NUM_PINS-1:0] flag;
  flagStrobe_t [NUM_PINS-1:0] strobe;

  eis_datapath #(
    .NUM_PINS   (NUM_PINS),
    .SYNC_STAGES(SYNC_STAGES),
    .IDLE_LEVEL (1'b1)
  ) i_datapath (
    .clk    (clk),
    .rstN   (rstN),
    .pinRaw (pinRaw),
    .strobe (strobe),
    .pinLvl (pinLvl),
    .pinPrev(pinPrev),
    .flag   (flag)
  );

  eis_control #(
    .NUM_PINS(NUM_PINS)
  ) i_control (
    .clk      (clk),
    .rstN     (rstN),
    .pinLvl   (pinLvl),
    .pinPrev  (pinPrev),
    .flag     (flag),
    .senseMode(senseMode),
    .intEnable(intEnable),
    .vecAck   (vecAck),
    .strobe   (strobe),
    .intReq   (intReq)
  );

endmodule

// File: tb/test_eis_top.sv
`timescale 1ns/1ps
module test_eis_top;

  localparam int N = 5;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic [N-1:0]   pinRaw = '1;
  logic [2*N-1:0] senseMode = '0;
  logic [N-1:0]   intEnable = '0;
  logic [N-1:0]   vecAck = '0;
  logic [N-1:0]   intReq;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  eis_top #(.NUM_PINS(N), .SYNC_STAGES(2)) i_eis_top (
    .clk(clk), .rstN(rstN), .pinRaw(pinRaw), .senseMode(senseMode),
    .intEnable(intEnable), .vecAck(vecAck), .intReq(intReq)
  );

  // cycle model built from the requirements
  logic [N-1:0] m1, m2, mp, mf;
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      m1 <= '1; m2 <= '1; mp <= '1; mf <= '0;
    end else begin
      m1 <= pinRaw;
      m2 <= m1;
      mp <= m2;
      for (int i = 0; i < N; i++) begin
        logic ev;
        ev = (senseMode[2*i +: 2] == 2'b10 && mp[i] && !m2[i]) ||
             (senseMode[2*i +: 2] == 2'b11 && !mp[i] && m2[i]);
        if (ev) mf[i] <= 1'b1;
        else if (vecAck[i]) mf[i] <= 1'b0;
      end
    end
  end

  function automatic logic [N-1:0] modelReq();
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) begin
      case (senseMode[2*i +: 2])
        2'b00:        r[i] = intEnable[i] & ~m2[i];
        2'b10, 2'b11: r[i] = intEnable[i] & mf[i];
        default:      r[i] = 1'b0;
      endcase
    end
    return r;
  endfunction

  task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: intReq=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic finishUp();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    bad++;
    $display("FAIL watchdog: run did not complete");
    finishUp();
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk); @(negedge clk);
    rstN = 1'b1;
    chk("R1 reset", intReq, 5'b00000);
    tick(2);
    chk("R1 idle after reset", intReq, 5'b00000);

    // R2 low level
    senseMode = '0; intEnable = '1;
    tick();
    chk("R2 high pins", intReq, 5'b00000);
    pinRaw[1] = 1'b0;
    tick();
    chk("R2 one clock", intReq, 5'b00000);
    tick();
    chk("R2 two clocks", intReq, 5'b00010);
    tick(5);
    chk("R2 held low", intReq, 5'b00010);
    pinRaw[1] = 1'b1;
    tick();
    chk("R2 release one clock", intReq, 5'b00010);
    tick();
    chk("R2 release two clocks", intReq, 5'b00000);

    // R3 falling edge
    senseMode = 10'b1010101010;
    tick();
    pinRaw[0] = 1'b0;
    tick(2);
    chk("R3 before flag", intReq, 5'b00000);
    tick();
    chk("R3 flag set", intReq, 5'b00001);
    pinRaw[0] = 1'b1;
    tick(3);
    chk("R3 latched", intReq, 5'b00001);
    vecAck[0] = 1'b1;
    tick();
    vecAck[0] = 1'b0;
    chk("R6 ack clears", intReq, 5'b00000);

    // R4 rising edge
    senseMode[5:4] = 2'b11;
    pinRaw[2] = 1'b0;
    tick(4);
    chk("R4 fall ignored", intReq, 5'b00000);
    pinRaw[2] = 1'b1;
    tick(3);
    chk("R4 rise sets", intReq, 5'b00100);
    vecAck[2] = 1'b1;
    tick();
    chk("R6 ack rise flag", intReq, 5'b00000);
    pinRaw[2] = 1'b0;
    tick(2);
    pinRaw[2] = 1'b1;
    tick(3);
    chk("R6 set wins over ack", intReq, 5'b00100);
    vecAck[2] = 1'b0;
    tick();
    chk("R6 flag kept", intReq, 5'b00100);
    vecAck[2] = 1'b1;
    tick();
    vecAck[2] = 1'b0;
    chk("R6 cleared", intReq, 5'b00000);

    // R5 reserved
    senseMode = 10'b0101010101;
    for (int k = 0; k < 12; k++) begin
      pinRaw = N'($urandom);
      tick();
      chk("R5 reserved quiet", intReq, 5'b00000);
    end
    pinRaw = '1;
    tick(3);

    // R7 disabled edge still latches
    senseMode = 10'b1010101010;
    intEnable = '0;
    vecAck = '1;
    tick();
    vecAck = '0;
    pinRaw[3] = 1'b0;
    tick(4);
    chk("R7 disabled no request", intReq, 5'b00000);
    intEnable[3] = 1'b1;
    #1;
    chk("R7 enable shows pending", intReq, 5'b01000);
    pinRaw[3] = 1'b1;
    intEnable = '1;
    vecAck = '1;
    tick();
    vecAck = '0;

    // R8 independence
    pinRaw[0] = 1'b0; pinRaw[4] = 1'b0;
    tick(3);
    chk("R8 two pending", intReq, 5'b10001);
    vecAck = 5'b00001;
    tick();
    vecAck = '0;
    chk("R8 only pin0 cleared", intReq, 5'b10000);
    pinRaw = '1;
    tick(3);

    // random phase against the cycle model
    for (int k = 0; k < 3000; k++) begin
      chk("R2 R3 R4 R6 R8 random", intReq, modelReq());
      for (int i = 0; i < N; i++) begin
        if ($urandom_range(5) == 0) pinRaw[i] = ~pinRaw[i];
        vecAck[i] = ($urandom_range(7) == 0);
        if ($urandom_range(40) == 0) intEnable[i] = ~intEnable[i];
        if ($urandom_range(60) == 0) senseMode[2*i +: 2] = 2'($urandom);
      end
      #1;
      chk("R7 random after input change", intReq, modelReq());
      @(posedge clk);
      @(negedge clk);
    end

    finishUp();
  end

endmodule